// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Controller

This block is a full-duplex 8-bit asynchronous serial controller with 8N1 framing. It sits on a small register bus and exposes a transmit line, a transmit-enable for the pad, and a receive line. A separate rate generator supplies a baud tick at 16 times the bit rate. The controller counts that tick to time and sample every bit.

Software writes characters into a one-deep transmit holding register, which drains into the serializer. Received characters pass from the deserializer into a two-stage store: a front holding register that software reads, and a second stage behind it. Up to two completed characters can therefore wait unread. Status flags change as a side effect of writing or reading the data register, so software never needs a separate clear operation.

Each direction has its own enable. A disabled transmitter releases its pad. An internal loopback turns the transmitter back into the receiver for self-test without touching the pins.

Top module: `uart_dbuf`

## Requirements
- R1: Register map: address 0 is data, address 1 is status, address 2 is control, and address 3 reads 0. The status bits are rx_valid[0], tx_empty[1], tx_done[2], frame_err[3] and overrun[4]. The control bits are tx_en[0], rx_en[1] and loop[2]. After reset, status reads 0x06, control reads 0x03, and txd_o is high.
- R2: A character written to the data register is sent on txd_o as one low start bit, then eight data bits LSB first, then one high stop bit. Each bit lasts 16 baud ticks.
- R3: tx_empty clears on a write to data and sets again when the held character moves into the serializer. A write made while tx_empty is 0 is ignored. Two accepted characters go out back to back.
- R4: tx_done clears on any accepted data write. It sets when a stop bit ends with no character pending.
- R5: The receiver takes a majority vote over tick samples 7, 8 and 9 of each bit. A start bit whose vote is high is dropped, and the line is then watched for a new start.
- R6: Up to two received characters are held. Reads of data return them oldest first. rx_valid clears when the last held character is read.
- R7: A character that completes while both receive stages are full is discarded and sets overrun. Overrun clears on the next data read.
- R8: A stop bit that votes low sets frame_err. The flag travels with its character, so frame_err reflects only the character currently at the front.
- R9: With tx_en at 0, txd_oe_o is 0 and txd_o stays high, and a written character waits until tx_en returns to 1. With rx_en at 0, frames on rxd_i are ignored.
- R10: With loop at 1, the transmitter feeds the receiver internally, txd_o stays high, and rxd_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| txd_oe_o | output | 1 | Transmit pad enable |

## Verification
Overrun is the hardest case to reach, because three full frames must arrive with no data read in between. Only then are the front register and the second stage both occupied when the third stop bit is voted. The bench therefore sends three frames in a row before it reads anything. It then drains the store and expects the first two characters in order, the overrun flag set, and the flag gone after the first read. Frames with a low stop bit are placed in both stages, so the bench can watch frame_err follow its character forward. Single-tick spikes near mid-bit and a short false start exercise the vote.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} ser_state_e;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_dbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              line_o,
  output logic              hold_empty_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  ser_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shift_q, hold_q;
  logic              hold_full_q, done_q;
  logic              wr_ok;

  assign wr_ok = wr_i && !hold_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      shift_q     <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      done_q      <= 1'b1;
    end else begin
      if (wr_ok) begin
        hold_q      <= wdata_i;
        hold_full_q <= 1'b1;
        done_q      <= 1'b0;
      end
      if (state_q == ST_IDLE) begin
        if (en_i && hold_full_q) begin
          shift_q     <= hold_q;
          hold_full_q <= 1'b0;
          state_q     <= ST_START;
          cnt_q       <= '0;
        end
      end else if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          unique case (state_q)
            ST_START: begin
              state_q <= ST_DATA;
              bit_q   <= '0;
            end
            ST_DATA: begin
              shift_q <= {1'b0, shift_q[DATA_W-1:1]};
              if (bit_q == BIT_LAST) state_q <= ST_STOP;
              else bit_q <= bit_q + 1'b1;
            end
            ST_STOP: begin
              if (hold_full_q) begin
                shift_q     <= hold_q;
                hold_full_q <= 1'b0;
                state_q     <= ST_START;
              end else begin
                state_q <= ST_IDLE;
                if (!wr_i) done_q <= 1'b1;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shift_q[0];
      default:  line_o = 1'b1;
    endcase
  end

  assign hold_empty_o = !hold_full_q;
  assign done_o       = done_q;

  // R3: an idle enabled serializer takes the held character on the next edge
  a_r3_hold_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && en_i && state_q == ST_IDLE) |=> !hold_full_q);
  // R4: done never shows while a frame is on the line
  a_r4_done_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !done_q);
  // R2: a frame always opens from the idle level
  a_r2_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_IDLE && state_q == ST_START) |-> $past(line_o));
endmodule

// File: rtl/uart_dbuf_rx.sv
module uart_dbuf_rx
  import uart_dbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] SMP_A    = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] SMP_B    = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] SMP_C    = CNT_W'(OSR / 2 + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic              sync1_q, sync2_q;
  ser_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shift_q;
  logic              vote_a_q, vote_b_q, maj;
  logic              at_vote, got_char;

  logic [DATA_W-1:0] hold_q, pend_q;
  logic              hold_full_q, pend_full_q, hold_fe_q, pend_fe_q, ovr_q;
  logic              pop_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd_i;
      sync2_q <= sync1_q;
    end
  end

  assign maj      = (vote_a_q & vote_b_q) | (vote_a_q & sync2_q) | (vote_b_q & sync2_q);
  assign at_vote  = en_i && tick_i && (state_q != ST_IDLE) && (cnt_q == SMP_C);
  assign got_char = at_vote && (state_q == ST_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      shift_q  <= '0;
      vote_a_q <= 1'b1;
      vote_b_q <= 1'b1;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (state_q == ST_IDLE) begin
        if (!sync2_q) begin
          state_q <= ST_START;
          cnt_q   <= CNT_W'(1);
        end
      end else begin
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == SMP_A) vote_a_q <= sync2_q;
        if (cnt_q == SMP_B) vote_b_q <= sync2_q;
        if (cnt_q == SMP_C) begin
          unique case (state_q)
            ST_START: if (maj) state_q <= ST_IDLE;
            ST_DATA:  shift_q <= {maj, shift_q[DATA_W-1:1]};
            ST_STOP:  state_q <= ST_IDLE;
            default:  ;
          endcase
        end
        if (cnt_q == CNT_LAST) begin
          if (state_q == ST_START) begin
            state_q <= ST_DATA;
            bit_q   <= '0;
          end else if (state_q == ST_DATA) begin
            if (bit_q == BIT_LAST) state_q <= ST_STOP;
            else bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign pop_ok = pop_i && hold_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      pend_q      <= '0;
      hold_full_q <= 1'b0;
      pend_full_q <= 1'b0;
      hold_fe_q   <= 1'b0;
      pend_fe_q   <= 1'b0;
      ovr_q       <= 1'b0;
    end else begin
      if (pop_ok) begin
        ovr_q <= 1'b0;
        if (pend_full_q) begin
          hold_q      <= pend_q;
          hold_fe_q   <= pend_fe_q;
          pend_full_q <= 1'b0;
        end else begin
          hold_full_q <= 1'b0;
          hold_fe_q   <= 1'b0;
        end
      end
      if (got_char) begin
        if (!hold_full_q || (pop_ok && !pend_full_q)) begin
          hold_q      <= shift_q;
          hold_full_q <= 1'b1;
          hold_fe_q   <= !maj;
        end else if (!pend_full_q || pop_ok) begin
          pend_q      <= shift_q;
          pend_full_q <= 1'b1;
          pend_fe_q   <= !maj;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  assign data_o  = hold_q;
  assign valid_o = hold_full_q;
  assign ferr_o  = hold_fe_q;
  assign ovr_o   = ovr_q;

  // R6: the back stage is only occupied behind a full front stage
  a_r6_pend_behind_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_full_q |-> hold_full_q);
  // R7: a discarded character leaves both stages untouched
  a_r7_overrun_keeps_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovr_q) && !$past(pop_ok)) |-> ($stable(hold_q) && $stable(pend_q)));
  // R8: a frame error belongs to a held character
  a_r8_fe_with_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_fe_q |-> hold_full_q);
  // R5: a start bit voting high returns the receiver to idle
  a_r5_false_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_vote && state_q == ST_START && maj) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/uart_dbuf.sv
module uart_dbuf
  import uart_dbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              txd_oe_o
);
  logic tx_en_q, rx_en_q, loop_q;
  logic tx_wr, rx_pop, tx_line, tx_empty, tx_done;
  logic rx_src, rx_valid, rx_fe, rx_ovr;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] stat_w, ctrl_w;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:3];

  assign tx_wr  = bus_sel_i && bus_we_i && bus_addr_i == ADDR_DATA;
  assign rx_pop = bus_sel_i && !bus_we_i && bus_addr_i == ADDR_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b1;
      rx_en_q <= 1'b1;
      loop_q  <= 1'b0;
    end else if (bus_sel_i && bus_we_i && bus_addr_i == ADDR_CTRL) begin
      tx_en_q <= bus_wdata_i[0];
      rx_en_q <= bus_wdata_i[1];
      loop_q  <= bus_wdata_i[2];
    end
  end

  uart_dbuf_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (baud_tick_i),
    .en_i         (tx_en_q),
    .wr_i         (tx_wr),
    .wdata_i      (bus_wdata_i),
    .line_o       (tx_line),
    .hold_empty_o (tx_empty),
    .done_o       (tx_done)
  );

  assign rx_src = loop_q ? tx_line : rxd_i;

  uart_dbuf_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .en_i    (rx_en_q),
    .rxd_i   (rx_src),
    .pop_i   (rx_pop),
    .data_o  (rx_data),
    .valid_o (rx_valid),
    .ferr_o  (rx_fe),
    .ovr_o   (rx_ovr)
  );

  assign txd_o    = (tx_en_q && !loop_q) ? tx_line : 1'b1;
  assign txd_oe_o = tx_en_q;

  assign stat_w = DATA_W'({rx_ovr, rx_fe, tx_done, tx_empty, rx_valid});
  assign ctrl_w = DATA_W'({loop_q, rx_en_q, tx_en_q});

  always_comb begin
    unique case (bus_addr_i)
      ADDR_DATA: bus_rdata_o = rx_data;
      ADDR_STAT: bus_rdata_o = stat_w;
      ADDR_CTRL: bus_rdata_o = ctrl_w;
      default:   bus_rdata_o = '0;
    endcase
  end

  // R9: a write with the transmitter off sends nothing until it is re-enabled
  a_r9_tx_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_q && $past(!tx_en_q)) |-> txd_o);
endmodule

// File: tb/uart_dbuf_test.sv
module uart_dbuf_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic sel = 0, we = 0, rxd = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic txd, txd_oe;
  int total = 0, bad = 0;
  int div = 0;
  logic [7:0] txq[$];
  int txd_lows = 0;

  always #10 clk = ~clk;

  uart_dbuf uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rxd_i(rxd), .txd_o(txd), .txd_oe_o(txd_oe)
  );

  always @(posedge clk) begin
    div  <= (div == 3) ? 0 : div + 1;
    tick <= (div == 3);
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // frame decoder on txd
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        logic [7:0] b;
        txd_lows++;
        repeat (30) @(negedge clk);
        check("R2 start", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (64) @(negedge clk);
          b[i] = txd;
        end
        repeat (64) @(negedge clk);
        check("R2 stop", txd, 1);
        txq.push_back(b);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk);
    sel = 0;
  endtask

  // stop_v: stop bit level; spike_bit: bit index (0..9) with a one-tick spike at mid-bit, -1 none
  task automatic send(input logic [7:0] b, input logic stop_v, input int spike_bit);
    logic [9:0] f;
    f = {stop_v, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        rxd = (i == spike_bit && c >= 32 && c < 36) ? ~f[i] : f[i];
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_tx(input int n);
    int t = 0;
    while (txq.size() < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  function automatic logic [7:0] stat(input bit rxv, input bit txe, input bit txd_,
                                      input bit fe, input bit ov);
    return {3'b0, ov, fe, txd_, txe, rxv};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, e1, e2;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd1, d); check("R1 status", d, 8'h06);
    rd(2'd2, d); check("R1 control", d, 8'h03);
    rd(2'd3, d); check("R1 addr3", d, 8'h00);
    check("R1 txd idle", txd, 1);

    // R2/R3/R4 directed back-to-back and ignored write
    wr(2'd0, 8'hA5);
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R3 empty after move", d[1], 1);
    check("R4 done cleared", d[2], 0);
    wr(2'd0, 8'h3C);
    rd(2'd1, d); check("R3 empty clears on write", d[1], 0);
    wr(2'd0, 8'hFF);
    wait_tx(2);
    repeat (200) @(negedge clk);
    check("R3 frame count", txq.size(), 2);
    if (txq.size() >= 2) begin
      check("R2 first byte", txq[0], 8'hA5);
      check("R3 second byte", txq[1], 8'h3C);
    end
    rd(2'd1, d); check("R4 done set", d, stat(0, 1, 1, 0, 0));
    txq.delete();

    // R2 random transmit
    for (int k = 0; k < 5; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      do rd(2'd1, d); while (d[1] == 1'b0);
      wr(2'd0, b);
      wait_tx(k + 1);
      if (txq.size() > k) check("R2 random byte", txq[k], b);
      else check("R2 random count", txq.size(), k + 1);
    end
    txq.delete();

    // R5/R6 random receive with spikes
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      send(b, 1'b1, int'($urandom % 11) - 1);
      rd(2'd1, d); check("R6 valid", d[0], 1);
      rd(2'd0, d); check("R5 majority byte", d, b);
      rd(2'd1, d); check("R6 valid clears", d[0], 0);
    end

    // R5 false start
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (700) @(negedge clk);
    rd(2'd1, d); check("R5 glitch dropped", d[0], 0);

    // R6 two-stage, R7 overrun
    e1 = 8'($urandom); e2 = 8'($urandom);
    send(e1, 1'b1, -1);
    send(e2, 1'b1, -1);
    rd(2'd1, d); check("R7 no overrun yet", d[4], 0);
    send(8'h77, 1'b1, -1);
    rd(2'd1, d); check("R7 overrun set", d, stat(1, 1, 1, 0, 1));
    rd(2'd0, d); check("R6 oldest first", d, e1);
    rd(2'd1, d); check("R7 overrun clears", d, stat(1, 1, 1, 0, 0));
    rd(2'd0, d); check("R7 third discarded", d, e2);
    rd(2'd1, d); check("R6 empty", d[0], 0);

    // R8 frame error travels with its char
    send(8'h5A, 1'b0, -1);
    send(8'hC3, 1'b1, -1);
    rd(2'd1, d); check("R8 fe on front", d[3], 1);
    rd(2'd0, d); check("R8 bad char", d, 8'h5A);
    rd(2'd1, d); check("R8 fe moved off", d, stat(1, 1, 1, 0, 0));
    rd(2'd0, d); check("R8 good char", d, 8'hC3);
    send(8'h11, 1'b1, -1);
    send(8'h22, 1'b0, -1);
    rd(2'd1, d); check("R8 back fe hidden", d[3], 0);
    rd(2'd0, d);
    rd(2'd1, d); check("R8 back fe forward", d[3], 1);
    rd(2'd0, d); check("R8 back char", d, 8'h22);

    // R9 transmitter disabled
    wr(2'd2, 8'h02);
    repeat (2) @(negedge clk);
    check("R9 oe off", txd_oe, 0);
    txd_lows = 0;
    wr(2'd0, 8'h96);
    repeat (800) @(negedge clk);
    check("R9 txd quiet", txd_lows, 0);
    rd(2'd1, d); check("R9 char waits", d[1], 0);
    wr(2'd2, 8'h03);
    wait_tx(1);
    repeat (100) @(negedge clk);
    if (txq.size() > 0) check("R9 sent after enable", txq[0], 8'h96);
    else check("R9 sent count", txq.size(), 1);
    txq.delete();

    // R9 receiver disabled
    wr(2'd2, 8'h01);
    send(8'hE1, 1'b1, -1);
    rd(2'd1, d); check("R9 rx ignored", d[0], 0);

    // R10 loopback, rxd_i held low
    wr(2'd2, 8'h07);
    @(negedge clk); rxd = 1'b0;
    txd_lows = 0;
    wr(2'd0, 8'h4B);
    repeat (800) @(negedge clk);
    check("R10 txd quiet", txd_lows, 0);
    rd(2'd1, d); check("R10 received", d[0], 1);
    rd(2'd0, d); check("R10 looped byte", d, 8'h4B);
    rd(2'd1, d); check("R10 rxd ignored", d[0], 0);
    rxd = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule